// File: doc/BRIEF.md
# Floating-Point Status and Trap Controller

This block keeps the control and status state that sits beside a floating-point arithmetic unit and decides, for every operation the unit completes, whether that operation raises a trap. Configuration goes to the arithmetic unit through two outputs: the rounding direction and a nonstandard-mode bit that allows subnormal values to be flushed to zero. The block also records which IEEE-754 exceptions the last operation produced and which have accumulated since software last cleared them. A trap-type code tells the trap handler why the most recent trap happened.

Each completed operation arrives as a one-cycle result strobe. The strobe carries five exception flags and indications for unfinished, unimplemented, sequence-error and subnormal cases, all computed upstream. A priority encoder classifies the event. A small state machine turns that class into a one-cycle trap request on either the IEEE-class line or the other-class line, in the cycle after the strobe. Software loads the writable fields through a single write port. The trap-type and version fields cannot be written.

Top module: `fp_status_ctl`

## Requirements
- R1: While reset is held and after it is released, rounding direction is 0, the nonstandard bit is 0, the current and accrued exception fields are 0, the trap type is 0, both trap lines are low, and the version output equals the `VERSION` parameter.
- R2: A write with `wr_en` high loads the following fields from `wr_data`. Bits [4:0] go to the current exceptions, bits [9:5] to the accrued exceptions, bits [14:10] to the trap mask, bits [16:15] to the rounding direction and bit 17 to the nonstandard bit. The trap-type field (bits [20:18]) and the version field (bits [23:21]) ignore writes. Rounding codes are 0 nearest-even, 1 toward zero, 2 toward +infinity and 3 toward -infinity.
- R3: Exception bits are ordered [4] invalid, [3] overflow, [2] underflow, [1] divide-by-zero, [0] inexact. A strobe that causes no trap does three things: it copies the flags into the current field, ORs them into the accrued field and sets the trap type to 0.
- R4: A strobe whose flags AND the trap mask is nonzero, with no other-class cause, does the following. It pulses `trap_ieee` in the next cycle, sets the trap type to 1, copies the flags into the current field and leaves the accrued field unchanged.
- R5: An unfinished operation pulses `trap_other` in the next cycle, sets the trap type to 2 and clears the current field. The accrued field is left unchanged.
- R6: An unimplemented operation does the same as R5 but with trap type 3, and it takes priority over unfinished.
- R7: A sequence error does the same as R5 but with trap type 4, and it takes priority over every other cause.
- R8: A subnormal indication with the nonstandard bit at 0 is handled as an unfinished operation (trap type 2). With the nonstandard bit at 1 it has no effect.
- R9: A write in the same cycle as a strobe wins. The register takes the written value, the strobe is discarded and no trap line pulses.
- R10: Trap lines are single-cycle pulses that are never high together. The trap type never takes the values 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Result strobe, one cycle per completed operation |
| op_exc | input | 5 | IEEE exception flags of the operation |
| op_unfin | input | 1 | Operation could not be finished in hardware |
| op_unimpl | input | 1 | Operation is not implemented |
| op_seqerr | input | 1 | Sequence error indication |
| op_subnorm | input | 1 | A subnormal operand or result was detected |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 24 | Software write value |
| rnd_dir | output | 2 | Rounding direction to the arithmetic unit |
| ns_mode | output | 1 | Nonstandard (flush-to-zero) mode |
| cur_exc | output | 5 | Current exception field |
| acc_exc | output | 5 | Accrued exception field |
| trap_type | output | 3 | Trap type of the latest event |
| ver_id | output | 3 | Read-only implementation version |
| trap_ieee | output | 1 | IEEE-class trap request pulse |
| trap_other | output | 1 | Other-class trap request pulse |

## Verification
A software write and a result strobe can land in the same cycle, and so can several trap causes in one strobe. The directed phase forces a write together with an enabled exception, and a sequence error together with unimplemented, unfinished and enabled flags. The random phase gives a high rate to writes, strobes and every cause bit, so these collisions come up often. Each outcome is compared against a bench model that applies write-wins and the cause priority order. Any difference in fields or pulses in the following cycle counts as a miscompare.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

    localparam int EXC_W  = 5;
    localparam int RND_W  = 2;
    localparam int FTT_W  = 3;
    localparam int VER_W  = 3;

    localparam int CUR_LSB  = 0;
    localparam int ACC_LSB  = CUR_LSB + EXC_W;
    localparam int MASK_LSB = ACC_LSB + EXC_W;
    localparam int RND_LSB  = MASK_LSB + EXC_W;
    localparam int NS_BIT   = RND_LSB + RND_W;
    localparam int FTT_LSB  = NS_BIT + 1;
    localparam int VER_LSB  = FTT_LSB + FTT_W;
    localparam int WORD_W   = VER_LSB + VER_W;

    typedef enum logic [FTT_W-1:0] {
        FTT_NONE   = 3'd0,
        FTT_IEEE   = 3'd1,
        FTT_UNFIN  = 3'd2,
        FTT_UNIMPL = 3'd3,
        FTT_SEQ    = 3'd4
    } ftt_e;

    typedef enum logic [RND_W-1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_POS_INF = 2'd2,
        RND_NEG_INF = 2'd3
    } rnd_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_WRITE,
        EV_CLEAN,
        EV_IEEE,
        EV_OTHER
    } ev_e;

endpackage

// File: rtl/fpsc_classify.sv
module fpsc_classify
    import fpsc_pkg::*;
(
    input  logic             op_valid,
    input  logic [EXC_W-1:0] op_exc,
    input  logic             op_unfin,
    input  logic             op_unimpl,
    input  logic             op_seqerr,
    input  logic             op_subnorm,
    input  logic             wr_en,
    input  logic             ns_mode,
    input  logic [EXC_W-1:0] trap_mask,
    output ev_e              ev,
    output ftt_e             ftt_new
);

    logic [EXC_W-1:0] hit;
    logic             any_hit;
    logic             unfin_eff;

    for (genvar i = 0; i < EXC_W; i++) begin : g_hit
        assign hit[i] = op_exc[i] & trap_mask[i];
    end

    assign any_hit   = |hit;
    assign unfin_eff = op_unfin | (op_subnorm & ~ns_mode);

    always_comb begin
        ev      = EV_NONE;
        ftt_new = FTT_NONE;
        if (wr_en) begin
            ev = EV_WRITE;
        end else if (op_valid) begin
            if (op_seqerr) begin
                ev      = EV_OTHER;
                ftt_new = FTT_SEQ;
            end else if (op_unimpl) begin
                ev      = EV_OTHER;
                ftt_new = FTT_UNIMPL;
            end else if (unfin_eff) begin
                ev      = EV_OTHER;
                ftt_new = FTT_UNFIN;
            end else if (any_hit) begin
                ev      = EV_IEEE;
                ftt_new = FTT_IEEE;
            end else begin
                ev      = EV_CLEAN;
                ftt_new = FTT_NONE;
            end
        end
    end

endmodule

// File: rtl/fpsc_trap_fsm.sv
module fpsc_trap_fsm
    import fpsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ev_e  ev,
    output logic trap_ieee,
    output logic trap_other
);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IEEE,
        ST_OTHER
    } st_e;

    st_e state_q;
    st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (ev)
            EV_IEEE:  state_d = ST_IEEE;
            EV_OTHER: state_d = ST_OTHER;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        trap_ieee  = 1'b0;
        trap_other = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_IEEE:  trap_ieee  = 1'b1;
            ST_OTHER: trap_other = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/fpsc_regs.sv
module fpsc_regs
    import fpsc_pkg::*;
#(
    parameter logic [VER_W-1:0] VERSION = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_e               ev,
    input  ftt_e              ftt_new,
    input  logic [EXC_W-1:0]  op_exc,
    input  logic [WORD_W-1:0] wr_data,
    output rnd_e              rnd_q,
    output logic              ns_q,
    output logic [EXC_W-1:0]  mask_q,
    output logic [EXC_W-1:0]  cur_q,
    output logic [EXC_W-1:0]  acc_q,
    output ftt_e              ftt_q,
    output logic [VER_W-1:0]  ver
);

    assign ver = VERSION;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q  <= RND_NEAREST;
            ns_q   <= 1'b0;
            mask_q <= '0;
            cur_q  <= '0;
            acc_q  <= '0;
            ftt_q  <= FTT_NONE;
        end else begin
            unique case (ev)
                EV_WRITE: begin
                    rnd_q  <= rnd_e'(wr_data[RND_LSB +: RND_W]);
                    ns_q   <= wr_data[NS_BIT];
                    mask_q <= wr_data[MASK_LSB +: EXC_W];
                    cur_q  <= wr_data[CUR_LSB +: EXC_W];
                    acc_q  <= wr_data[ACC_LSB +: EXC_W];
                end
                EV_CLEAN: begin
                    cur_q <= op_exc;
                    acc_q <= acc_q | op_exc;
                    ftt_q <= FTT_NONE;
                end
                EV_IEEE: begin
                    cur_q <= op_exc;
                    ftt_q <= FTT_IEEE;
                end
                EV_OTHER: begin
                    cur_q <= '0;
                    ftt_q <= ftt_new;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fp_status_ctl.sv
module fp_status_ctl
    import fpsc_pkg::*;
#(
    parameter logic [VER_W-1:0] VERSION = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [EXC_W-1:0]  op_exc,
    input  logic              op_unfin,
    input  logic              op_unimpl,
    input  logic              op_seqerr,
    input  logic              op_subnorm,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [RND_W-1:0]  rnd_dir,
    output logic              ns_mode,
    output logic [EXC_W-1:0]  cur_exc,
    output logic [EXC_W-1:0]  acc_exc,
    output logic [FTT_W-1:0]  trap_type,
    output logic [VER_W-1:0]  ver_id,
    output logic              trap_ieee,
    output logic              trap_other
);

    ev_e              ev;
    ftt_e             ftt_new;
    rnd_e             rnd_q;
    ftt_e             ftt_q;
    logic [EXC_W-1:0] trap_mask;

    fpsc_classify u_classify (
        .op_valid   (op_valid),
        .op_exc     (op_exc),
        .op_unfin   (op_unfin),
        .op_unimpl  (op_unimpl),
        .op_seqerr  (op_seqerr),
        .op_subnorm (op_subnorm),
        .wr_en      (wr_en),
        .ns_mode    (ns_mode),
        .trap_mask  (trap_mask),
        .ev         (ev),
        .ftt_new    (ftt_new)
    );

    fpsc_regs #(.VERSION(VERSION)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .ftt_new (ftt_new),
        .op_exc  (op_exc),
        .wr_data (wr_data),
        .rnd_q   (rnd_q),
        .ns_q    (ns_mode),
        .mask_q  (trap_mask),
        .cur_q   (cur_exc),
        .acc_q   (acc_exc),
        .ftt_q   (ftt_q),
        .ver     (ver_id)
    );

    fpsc_trap_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .trap_ieee  (trap_ieee),
        .trap_other (trap_other)
    );

    assign rnd_dir   = rnd_q;
    assign trap_type = ftt_q;

endmodule

// File: rtl/fpsc_chk.sv
module fpsc_chk
    import fpsc_pkg::*;
#(
    parameter logic [VER_W-1:0] VERSION = 3'd1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             wr_en,
    input logic [EXC_W-1:0] mask,
    input logic [EXC_W-1:0] cur_exc,
    input logic [EXC_W-1:0] acc_exc,
    input logic [FTT_W-1:0] trap_type,
    input logic [VER_W-1:0] ver_id,
    input logic             trap_ieee,
    input logic             trap_other
);

    // R1, R2: version never moves
    a_r2_ver_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ver_id == VERSION);

    // R4: IEEE trap implies an enabled flag, type 1, accrued untouched
    a_r4_ieee_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ieee |-> (((cur_exc & mask) != '0) && (trap_type == 3'd1) && $stable(acc_exc)));

    // R5, R6, R7: other-class trap clears current field, type in 2..4
    a_r5_other_clear: assert property (@(posedge clk) disable iff (!rst_n)
        trap_other |-> ((cur_exc == '0) && (trap_type >= 3'd2) && (trap_type <= 3'd4)));

    // R9: a write cycle never produces a trap
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (!trap_ieee && !trap_other));

    // R10: exclusive pulses, legal trap type, pulses only after a strobe
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_ieee && trap_other));

    a_r10_ftt_legal: assert property (@(posedge clk) disable iff (!rst_n)
        trap_type <= 3'd4);

    a_r10_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ieee || trap_other) |-> $past(op_valid));

endmodule

bind fp_status_ctl fpsc_chk #(.VERSION(VERSION)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .wr_en      (wr_en),
    .mask       (trap_mask),
    .cur_exc    (cur_exc),
    .acc_exc    (acc_exc),
    .trap_type  (trap_type),
    .ver_id     (ver_id),
    .trap_ieee  (trap_ieee),
    .trap_other (trap_other)
);

// File: tb/fp_status_ctl_tb.sv
module fp_status_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] VER = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_unfin, op_unimpl, op_seqerr, op_subnorm, wr_en;
    logic [4:0]  op_exc;
    logic [23:0] wr_data;
    logic [1:0]  rnd_dir;
    logic        ns_mode, trap_ieee, trap_other;
    logic [4:0]  cur_exc, acc_exc;
    logic [2:0]  trap_type, ver_id;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [1:0] m_rnd;
    logic       m_ns;
    logic [4:0] m_mask, m_cur, m_acc;
    logic [2:0] m_ftt;
    logic       m_ti, m_to;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_status_ctl #(.VERSION(VER)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_exc(op_exc),
        .op_unfin(op_unfin), .op_unimpl(op_unimpl), .op_seqerr(op_seqerr),
        .op_subnorm(op_subnorm), .wr_en(wr_en), .wr_data(wr_data),
        .rnd_dir(rnd_dir), .ns_mode(ns_mode), .cur_exc(cur_exc),
        .acc_exc(acc_exc), .trap_type(trap_type), .ver_id(ver_id),
        .trap_ieee(trap_ieee), .trap_other(trap_other)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] wword(input logic [1:0] r, input logic n,
                                          input logic [4:0] m, input logic [4:0] a,
                                          input logic [4:0] c);
        return {3'b111, 3'b111, n, r, m, a, c};
    endfunction

    task automatic compare(input string tag);
        chk(tag, "rnd_dir", rnd_dir, m_rnd);
        chk(tag, "ns_mode", ns_mode, m_ns);
        chk(tag, "cur_exc", cur_exc, m_cur);
        chk(tag, "acc_exc", acc_exc, m_acc);
        chk(tag, "trap_type", trap_type, m_ftt);
        chk(tag, "ver_id", ver_id, VER);
        chk(tag, "trap_ieee", trap_ieee, m_ti);
        chk(tag, "trap_other", trap_other, m_to);
        chk("R10", "ftt_legal", (trap_type <= 3'd4), 1);
        chk("R10", "pulse_excl", (trap_ieee & trap_other), 0);
    endtask

    task automatic apply(input logic v, input logic [4:0] e, input logic uf,
                         input logic ui, input logic sq, input logic sb,
                         input logic we, input logic [23:0] wd);
        string tag;
        op_valid = v; op_exc = e; op_unfin = uf; op_unimpl = ui;
        op_seqerr = sq; op_subnorm = sb; wr_en = we; wr_data = wd;
        m_ti = 1'b0; m_to = 1'b0; tag = "R3";
        if (we) begin
            tag = v ? "R9" : "R2";
            m_rnd = wd[16:15]; m_ns = wd[17]; m_mask = wd[14:10];
            m_acc = wd[9:5]; m_cur = wd[4:0];
        end else if (v) begin
            if (sq) begin
                tag = "R7"; m_ftt = 3'd4; m_cur = '0; m_to = 1'b1;
            end else if (ui) begin
                tag = "R6"; m_ftt = 3'd3; m_cur = '0; m_to = 1'b1;
            end else if (uf || (sb && !m_ns)) begin
                tag = uf ? "R5" : "R8"; m_ftt = 3'd2; m_cur = '0; m_to = 1'b1;
            end else if ((e & m_mask) != 0) begin
                tag = sb ? "R8" : "R4"; m_ftt = 3'd1; m_cur = e; m_ti = 1'b1;
            end else begin
                tag = sb ? "R8" : "R3"; m_ftt = 3'd0; m_cur = e; m_acc = m_acc | e;
            end
        end else begin
            tag = "R10";
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        op_valid = 0; op_exc = 0; op_unfin = 0; op_unimpl = 0;
        op_seqerr = 0; op_subnorm = 0; wr_en = 0; wr_data = 0;
        m_rnd = 0; m_ns = 0; m_mask = 0; m_cur = 0; m_acc = 0; m_ftt = 0;
        m_ti = 0; m_to = 0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R2: all-ones write; ftt and version must ignore it
        apply(0, 0, 0, 0, 0, 0, 1, 24'hFFFFFF);
        // R2: enable only invalid, round toward +inf
        apply(0, 0, 0, 0, 0, 0, 1, wword(2'd2, 1'b0, 5'b10000, 5'd0, 5'd0));
        // R3: inexact + divide-by-zero, not enabled
        apply(1, 5'b00011, 0, 0, 0, 0, 0, 0);
        // R4: invalid enabled
        apply(1, 5'b10001, 0, 0, 0, 0, 0, 0);
        // R10: idle cycle, pulse must drop
        apply(0, 0, 0, 0, 0, 0, 0, 0);
        // R5
        apply(1, 5'b00100, 1, 0, 0, 0, 0, 0);
        // R6: unimplemented beats unfinished
        apply(1, 5'b10000, 1, 1, 0, 0, 0, 0);
        // R7: sequence error beats everything
        apply(1, 5'b10000, 1, 1, 1, 1, 0, 0);
        // R8: subnormal with standard mode
        apply(1, 5'b00001, 0, 0, 0, 1, 0, 0);
        // R8: nonstandard mode, subnormal ignored
        apply(0, 0, 0, 0, 0, 0, 1, wword(2'd1, 1'b1, 5'b00001, 5'd0, 5'd0));
        apply(1, 5'b00100, 0, 0, 0, 1, 0, 0);
        // R9: write with an enabled exception in the same cycle
        apply(1, 5'b00001, 0, 0, 0, 0, 1, wword(2'd3, 1'b0, 5'b11111, 5'd3, 5'd0));
        apply(0, 0, 0, 0, 0, 0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            logic v, we;
            logic [4:0] e;
            v  = ($urandom % 4) != 0;
            we = ($urandom % 8) == 0;
            e  = 5'($urandom);
            apply(v, e, ($urandom % 8) == 0, ($urandom % 10) == 0,
                  ($urandom % 12) == 0, ($urandom % 6) == 0, we, 24'($urandom));
        end
        apply(0, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule